// File: doc/BRIEF.md
# Branch Next-PC Unit with Delay Slot

This block holds the program counter of a small microcontroller and picks the next PC each time an instruction retires. A conditional branch can compare a source register with a 5-bit immediate, or it can test one bit of that register chosen by a 5-bit index. A polarity flag picks the sense of the test: equal or bit set, versus not-equal or bit clear. There is also an unconditional jump. The target is the branch's own PC plus a sign-extended 16-bit offset.

Every taken branch is followed by exactly one delay-slot instruction, which always executes. The redirect takes effect only after that slot retires. A branch that sits in a delay slot is ignored. The decode stage presents the decoded fields of the instruction at `pc_o` and pulses `adv_i` when that instruction retires.

Top module: `bcu_npc`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0 and `slot_o` is 0.
- R2: When `adv_i` is 1, the instruction is not a taken branch and `slot_o` is 0, `pc_o` becomes `pc_o`+1 modulo 2^16 on the next edge.
- R3: When `adv_i` is 0, `pc_o` and `slot_o` keep their values.
- R4: With `kind_i`=2'b01 and `bit_mode_i`=0, the branch is taken when `pol_i`=1 and `src_i` equals the zero-extended `sel_i`. It is taken when `pol_i`=0 and they differ.
- R5: With `kind_i`=2'b01 and `bit_mode_i`=1, the branch is taken when `pol_i`=1 and `src_i[sel_i]` is 1. It is taken when `pol_i`=0 and that bit is 0.
- R6: With `kind_i`=2'b10 (jump), the branch is always taken. Codes 2'b00 and 2'b11 are never taken.
- R7: When a taken branch at PC p retires, `pc_o` becomes p+1 and `slot_o` becomes 1. When the slot then retires, `pc_o` becomes p + sign-extended `off_i` modulo 2^16 and `slot_o` becomes 0.
- R8: While `slot_o` is 1, `taken_o` is 0 whatever the inputs are. A branch in the slot does not change the pending target.
- R9: `taken_o` is a combinational output. It is 1 exactly when `slot_o` is 0 and the presented instruction is taken under R4 to R6, and it does not depend on `adv_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| adv_i | input | 1 | The instruction at `pc_o` retires this cycle |
| kind_i | input | 2 | 00 none, 01 conditional, 10 jump, 11 none |
| src_i | input | 32 | Source register value |
| sel_i | input | 5 | Immediate or bit index |
| bit_mode_i | input | 1 | 1 selects the bit test, 0 selects the immediate compare |
| pol_i | input | 1 | 1 selects equal or set, 0 selects not-equal or clear |
| off_i | input | 16 | Signed offset relative to the branch PC |
| pc_o | output | 16 | Current PC |
| slot_o | output | 1 | The instruction at `pc_o` is a delay slot |
| taken_o | output | 1 | The presented instruction redirects the PC |

## Verification
`taken_o` settles in the same cycle as its inputs, so the bench drives each instruction at the falling edge and samples `taken_o` 1 ns later. `pc_o` and `slot_o` pass through one register. The bench therefore compares them with its model at the next falling edge, half a period after the rising edge that retires the instruction. A redirect shows up two retirements after the branch: the first retirement moves to the delay slot and the second retirement goes to the target. The model keeps the target from the first branch and checks for it at that second retirement.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  typedef enum logic [1:0] {
    K_NONE = 2'b00,
    K_COND = 2'b01,
    K_JUMP = 2'b10,
    K_RSVD = 2'b11
  } br_kind_e;
endpackage

// File: rtl/bcu_cond.sv
module bcu_cond #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = $clog2(DATA_W)
) (
  input  logic [1:0]        kind_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              bit_mode_i,
  input  logic              pol_i,
  output logic              hit_o
);
  import bcu_pkg::*;
  localparam int PAD_W = DATA_W - SEL_W;

  logic eq_imm, bit_set, raw;

  assign eq_imm  = (src_i == {{PAD_W{1'b0}}, sel_i});
  assign bit_set = src_i[sel_i];
  assign raw     = bit_mode_i ? bit_set : eq_imm;

  always_comb begin
    unique case (br_kind_e'(kind_i))
      K_COND:  hit_o = (raw == pol_i);
      K_JUMP:  hit_o = 1'b1;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcu_tgt.sv
module bcu_tgt #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 16
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PC_W-1:0]  tgt_o,
  output logic [PC_W-1:0]  seq_o
);
  logic [PC_W-1:0] off_ext;

  generate
    if (OFF_W >= PC_W) begin : g_trunc
      assign off_ext = off_i[PC_W-1:0];
    end else begin : g_sext
      assign off_ext = {{(PC_W-OFF_W){off_i[OFF_W-1]}}, off_i};
    end
  endgenerate

  assign tgt_o = pc_i + off_ext;
  assign seq_o = pc_i + PC_W'(1);
endmodule

// File: rtl/bcu_npc.sv
module bcu_npc #(
  parameter int PC_W   = 16,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  parameter int SEL_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [1:0]        kind_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              bit_mode_i,
  input  logic              pol_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              slot_o,
  output logic              taken_o
);
  logic [PC_W-1:0] pc_q, tgt_q, tgt_d, seq_d;
  logic            pend_q, hit;

  bcu_cond #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_cond (
    .kind_i(kind_i), .src_i(src_i), .sel_i(sel_i),
    .bit_mode_i(bit_mode_i), .pol_i(pol_i), .hit_o(hit)
  );

  bcu_tgt #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
    .pc_i(pc_q), .off_i(off_i), .tgt_o(tgt_d), .seq_o(seq_d)
  );

  // a branch sitting in a delay slot is squashed
  assign taken_o = hit & ~pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      tgt_q  <= '0;
      pend_q <= 1'b0;
    end else if (adv_i) begin
      if (pend_q) begin
        pc_q   <= tgt_q;
        pend_q <= 1'b0;
      end else begin
        pc_q   <= seq_d;
        pend_q <= taken_o;
        if (taken_o) tgt_q <= tgt_d;
      end
    end
  end

  assign pc_o   = pc_q;
  assign slot_o = pend_q;

  a_r8_no_slot_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o |-> !taken_o);
  a_r7_enter_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && taken_o) |=> (slot_o && pc_o == $past(pc_o) + PC_W'(1)));
  a_r7_single_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && slot_o) |=> !slot_o);
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> ($stable(pc_o) && $stable(slot_o)));
  a_r2_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !slot_o && !taken_o) |=> (!slot_o && pc_o == $past(pc_o) + PC_W'(1)));
endmodule

// File: tb/bcu_npc_test.sv
module bcu_npc_test;
  logic        clk = 0, rst_ni = 0, adv_i = 0, bit_mode_i = 0, pol_i = 0;
  logic [1:0]  kind_i = 0;
  logic [31:0] src_i = 0;
  logic [4:0]  sel_i = 0;
  logic [15:0] off_i = 0, pc_o;
  logic        slot_o, taken_o;

  int n_run = 0, n_fail = 0;
  logic [15:0] m_pc = 0, m_tgt = 0;
  logic        m_pend = 0;

  always #2 clk = ~clk;

  bcu_npc uut (.clk_i(clk), .rst_ni(rst_ni), .adv_i(adv_i), .kind_i(kind_i),
    .src_i(src_i), .sel_i(sel_i), .bit_mode_i(bit_mode_i), .pol_i(pol_i),
    .off_i(off_i), .pc_o(pc_o), .slot_o(slot_o), .taken_o(taken_o));

  function automatic logic f_hit(logic [1:0] k, logic [31:0] s, logic [4:0] x,
                                 logic bm, logic p);
    logic r;
    r = bm ? s[x] : (s == {27'd0, x});
    if (k == 2'b01) return r == p;
    return k == 2'b10;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, check taken, retire at posedge, check state at next negedge
  task automatic step(input logic a, input logic [1:0] k, input logic [31:0] s,
                      input logic [4:0] x, input logic bm, input logic p,
                      input logic [15:0] o, input string tag);
    logic t;
    adv_i = a; kind_i = k; src_i = s; sel_i = x; bit_mode_i = bm; pol_i = p; off_i = o;
    #1;
    t = f_hit(k, s, x, bm, p) & ~m_pend;
    chk(taken_o, t, m_pend ? "R8 taken" : tag);
    if (a) begin
      if (m_pend) begin m_pc = m_tgt; m_pend = 0; end
      else begin
        if (t) begin m_tgt = m_pc + o; m_pend = 1; end
        m_pc = m_pc + 1;
      end
    end
    @(negedge clk);
    chk(pc_o, m_pc, a ? "R7 pc" : "R3 pc");
    chk(slot_o, m_pend, a ? "R7 slot" : "R3 slot");
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog act=hang exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #5;
    chk(pc_o, 0, "R1 pc");
    chk(slot_o, 0, "R1 slot");
    @(negedge clk); rst_ni = 1; @(negedge clk);
    step(1, 2'b00, 0, 0, 0, 0, 0, "R2 seq");
    step(0, 2'b10, 0, 0, 0, 0, 16'h10, "R3 stall");
    step(1, 2'b01, 32'd7, 5'd7, 0, 1, 16'h20, "R4 eq");
    step(1, 2'b10, 0, 0, 0, 0, 16'h5, "R8 slot jump");
    step(1, 2'b01, 32'd7, 5'd6, 0, 1, 16'h20, "R4 eq miss");
    step(1, 2'b01, 32'd7, 5'd6, 0, 0, 16'h3, "R4 ne");
    step(1, 2'b00, 0, 0, 0, 0, 0, "R7 slot");
    step(1, 2'b01, 32'h8000_0000, 5'd31, 1, 1, 16'hfff0, "R5 set");
    step(1, 2'b00, 0, 0, 0, 0, 0, "R7 slot");
    step(1, 2'b01, 32'h8000_0000, 5'd31, 1, 0, 16'h4, "R5 clear miss");
    step(1, 2'b01, 32'h0, 5'd0, 1, 0, 16'h4, "R5 clear");
    step(1, 2'b00, 0, 0, 0, 0, 0, "R7 slot");
    step(1, 2'b11, 0, 0, 0, 0, 16'h4, "R6 rsvd");
    step(1, 2'b01, 32'h0, 5'd0, 0, 1, 16'h4, "R6 zero-reg branch");
    step(1, 2'b00, 0, 0, 0, 0, 0, "R7 slot");
    // wrap: jump back past zero
    step(1, 2'b10, 0, 0, 0, 0, 16'h8000 - m_pc + 16'h7fff, "R6 jump");
    step(1, 2'b00, 0, 0, 0, 0, 0, "R7 slot");
    step(1, 2'b10, 0, 0, 0, 0, 16'h0 - m_pc + 16'hffff, "R6 jump");
    step(1, 2'b00, 0, 0, 0, 0, 0, "R7 slot");
    step(1, 2'b00, 0, 0, 0, 0, 0, "R2 wrap");
    chk(pc_o, 0, "R2 wrap zero");
    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  k = 2'($urandom);
      logic [4:0]  x = 5'($urandom);
      logic [31:0] s = ($urandom % 3 == 0) ? {27'd0, x} : $urandom;
      step(($urandom % 5) != 0, k, s, x, 1'($urandom), 1'($urandom), 16'($urandom),
           k == 2'b10 ? "R6 rnd" : "R9 rnd");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule